// File: doc/BRIEF.md
# Adjustable Hardware Time Counter

This block keeps a free-running 64-bit system time for stamping packets. Software sets the rate through an increment register. Its low 24 bits hold a step value, which may carry fractional nanoseconds. Its top 8 bits hold a period: the number of base clock cycles between two additions. A run/stop bit in an auxiliary control register freezes the time or lets it advance.

The time is spread over three 32-bit registers: a sub-unit residue word, a low word and a high word.

- Reading the lowest-order word takes a snapshot of the whole value. Later reads of the higher words return that snapshot, so software always sees one coherent value.
- Writes are staged the same way. The residue and low words are held back until the high word is written. That write then loads all three into the counter in a single cycle.

A build-time option swaps the programmable rate for a fixed rate of 8 units per base cycle, which suits an 8 ns base clock.

Top module: `adj_time_counter`

## Requirements
- R1: After reset the time and residue are zero and the counter is running (auxiliary register reads 0x00000000). The increment register reads zero, and a high-word read (0x8) made before any snapshot returns zero.
- R2: The increment register (0xC) has the step in bits [23:0] and the period P in bits [31:24]. While running, the step is added once every P base cycles. The divider phase restarts when the increment register is written.
- R3: A period field of 0 stops all additions. The time holds while the counter is otherwise running.
- R4: A read of the residue word (0x0) returns the live residue and snapshots the time. Later reads of the low (0x4) and high (0x8) words return the snapshot, not the advancing time.
- R5: Writes to the residue (0x0) and low (0x4) words are only staged and leave the time and residue unchanged. A write to the high word (0x8) loads {high, staged low} and the staged residue together.
- R6: When a high-word commit falls in the same cycle as an addition, the written value is loaded and no step is added in that cycle.
- R7: Bit 31 of the auxiliary register (0x10) set to 1 stops the time, and 0 lets it run. The register reads back as that bit alone.
- R8: The time wraps modulo 2^64 with no error. This includes preloads just below rollover.
- R9: In fixed-rate mode the time grows by exactly 8 on every running cycle, and the increment register has no effect on it.
- R10: The increment register reads back exactly the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Single-cycle read strobe; a read of the lowest word takes the snapshot |
| rd_addr | input | 5 | Read byte address |
| rd_data | output | 32 | Combinational read data for rd_addr |

## Verification
Read data is combinational, so each read is sampled in the same cycle it is issued. The snapshot it triggers is taken at the following edge. A write takes effect at the edge that ends its strobe cycle. A run command enables additions from the next edge on, and a stop command still lets the addition at its own edge happen. The bench therefore expects exactly N running edges between a run write and the stop write N cycles later, and checks floor(N/P) additions against that count. The commit-versus-addition case places the stop one cycle after the commit, so the result is the written value plus exactly one step.

// File: rtl/atc_pkg.sv
package atc_pkg;
   localparam int ATC_ADDR_W = 5;
   localparam logic [ATC_ADDR_W-1:0] ATC_A_RES  = 5'h00;
   localparam logic [ATC_ADDR_W-1:0] ATC_A_LO   = 5'h04;
   localparam logic [ATC_ADDR_W-1:0] ATC_A_HI   = 5'h08;
   localparam logic [ATC_ADDR_W-1:0] ATC_A_INCR = 5'h0C;
   localparam logic [ATC_ADDR_W-1:0] ATC_A_AUX  = 5'h10;
   localparam int ATC_STOP_BIT = 31;
endpackage

// File: rtl/atc_tick_gen.sv
module atc_tick_gen #(
   parameter int ADD_W  = 24,
   parameter int PER_W  = 8,
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              incr_wr,
   input  logic [ADD_W-1:0]  add_val,
   input  logic [PER_W-1:0]  period,
   output logic              tick,
   output logic [TIME_W-1:0] step
);
   logic [PER_W-1:0] div_cnt;
   logic             per_ok;
   logic             wrap;

   assign per_ok = (period != '0);
   assign wrap   = per_ok && (div_cnt == period - 1'b1);
   assign tick   = run && wrap;
   assign step   = {{(TIME_W-ADD_W){1'b0}}, add_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            div_cnt <= '0;
      else if (incr_wr)      div_cnt <= '0;
      else if (run && per_ok) div_cnt <= wrap ? '0 : div_cnt + 1'b1;
   end

   AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      per_ok |-> (div_cnt < period)); // R2
endmodule

// File: rtl/atc_time_core.sv
module atc_time_core #(
   parameter int TIME_W = 64,
   parameter int RES_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TIME_W-1:0] step,
   input  logic              commit,
   input  logic [TIME_W-1:0] load_time,
   input  logic [RES_W-1:0]  load_res,
   output logic [TIME_W-1:0] time_q,
   output logic [RES_W-1:0]  res_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         time_q <= '0;
         res_q  <= '0;
      end else if (commit) begin
         time_q <= load_time;
         res_q  <= load_res;
      end else if (tick) begin
         time_q <= time_q + step;
      end
   end

   AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (time_q == $past(load_time)) && (res_q == $past(load_res))); // R5
   AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && tick) |=> (time_q == $past(load_time))); // R6
   AST_TICK_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !commit) |=> (time_q == $past(time_q) + $past(step))); // R8
endmodule

// File: rtl/atc_access.sv
module atc_access
   import atc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int TIME_W      = 64,
   parameter bit HAS_RESIDUE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ATC_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [ATC_ADDR_W-1:0] rd_addr,
   input  logic [TIME_W-1:0]     time_q,
   input  logic [DATA_W-1:0]     res_q,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  commit,
   output logic [TIME_W-1:0]     load_time,
   output logic [DATA_W-1:0]     load_res,
   output logic                  incr_wr,
   output logic [DATA_W-1:0]     incr_q,
   output logic                  run
);
   localparam logic [ATC_ADDR_W-1:0] LOWEST = HAS_RESIDUE ? ATC_A_RES : ATC_A_LO;

   logic [DATA_W-1:0] stage_lo, stage_res, shadow_lo, shadow_hi;
   logic              stop_q;
   logic              cap;

   assign cap       = rd_en && (rd_addr == LOWEST);
   assign commit    = wr_en && (wr_addr == ATC_A_HI);
   assign incr_wr   = wr_en && (wr_addr == ATC_A_INCR);
   assign load_time = {wr_data, stage_lo};
   assign run       = !stop_q;

   generate
      if (HAS_RESIDUE) begin : g_res
         assign load_res = stage_res;
      end else begin : g_nores
         assign load_res = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_lo  <= '0;
         stage_res <= '0;
         incr_q    <= '0;
         stop_q    <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            ATC_A_RES:  stage_res <= wr_data;
            ATC_A_LO:   stage_lo  <= wr_data;
            ATC_A_INCR: incr_q    <= wr_data;
            ATC_A_AUX:  stop_q    <= wr_data[ATC_STOP_BIT];
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_lo <= '0;
         shadow_hi <= '0;
      end else if (cap) begin
         shadow_lo <= time_q[DATA_W-1:0];
         shadow_hi <= time_q[TIME_W-1:DATA_W];
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ATC_A_RES:  rd_data = HAS_RESIDUE ? res_q : '0;
         ATC_A_LO:   rd_data = HAS_RESIDUE ? shadow_lo : time_q[DATA_W-1:0];
         ATC_A_HI:   rd_data = shadow_hi;
         ATC_A_INCR: rd_data = incr_q;
         ATC_A_AUX:  rd_data[ATC_STOP_BIT] = stop_q;
         default:    rd_data = '0;
      endcase
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable({shadow_hi, shadow_lo})); // R4
endmodule

// File: rtl/adj_time_counter.sv
module adj_time_counter
   import atc_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int TIME_W      = 64,
   parameter int ADD_W       = 24,
   parameter bit HAS_RESIDUE = 1'b1,
   parameter bit FIXED_MODE  = 1'b0,
   parameter int FIXED_STEP  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ATC_ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  rd_en,
   input  logic [ATC_ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0]     rd_data
);
   localparam int PER_W = DATA_W - ADD_W;

   generate
      if (TIME_W != 2 * DATA_W) begin : g_bad_time
         $error("TIME_W must span exactly two data words");
      end
      if (ADD_W < 1 || ADD_W >= DATA_W) begin : g_bad_add
         $error("ADD_W must leave room for a period field");
      end
   endgenerate

   logic              commit, incr_wr, run, tick;
   logic [TIME_W-1:0] load_time, time_q, step;
   logic [DATA_W-1:0] load_res, res_q, incr_q;

   atc_access #(
      .DATA_W(DATA_W), .TIME_W(TIME_W), .HAS_RESIDUE(HAS_RESIDUE)
   ) u_access (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .time_q(time_q), .res_q(res_q), .rd_data(rd_data),
      .commit(commit), .load_time(load_time), .load_res(load_res),
      .incr_wr(incr_wr), .incr_q(incr_q), .run(run)
   );

   generate
      if (FIXED_MODE) begin : g_fixed
         assign tick = run;
         assign step = TIME_W'(FIXED_STEP);

         AST_FIXED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !commit) |=> (time_q == $past(time_q) + TIME_W'(FIXED_STEP))); // R9
      end else begin : g_prog
         atc_tick_gen #(
            .ADD_W(ADD_W), .PER_W(PER_W), .TIME_W(TIME_W)
         ) u_tick (
            .clk(clk), .rst_n(rst_n), .run(run), .incr_wr(incr_wr),
            .add_val(incr_q[ADD_W-1:0]), .period(incr_q[DATA_W-1:ADD_W]),
            .tick(tick), .step(step)
         );

         AST_PERIOD_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ((incr_q[DATA_W-1:ADD_W] == '0) && !commit) |=> $stable(time_q)); // R3
      end
   endgenerate

   atc_time_core #(
      .TIME_W(TIME_W), .RES_W(DATA_W)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .step(step),
      .commit(commit), .load_time(load_time), .load_res(load_res),
      .time_q(time_q), .res_q(res_q)
   );

   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !commit) |=> $stable(time_q)); // R7
endmodule

// File: tb/adj_time_counter_bench.sv
module adj_time_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_wr_en = 0, a_rd_en = 0, f_wr_en = 0, f_rd_en = 0;
   logic [4:0]  a_wr_addr = 0, a_rd_addr = 0, f_wr_addr = 0, f_rd_addr = 0;
   logic [31:0] a_wr_data = 0, f_wr_data = 0;
   logic [31:0] a_rd_data, f_rd_data;
   int n_chk = 0;
   int n_fail = 0;

   localparam logic [4:0] RES = 5'h00, LO = 5'h04, HI = 5'h08, INC = 5'h0C, AUX = 5'h10;
   localparam logic [31:0] STOP = 32'h8000_0000;

   always #4 clk = ~clk;

   adj_time_counter u_adj_time_counter (
      .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_addr(a_wr_addr),
      .wr_data(a_wr_data), .rd_en(a_rd_en), .rd_addr(a_rd_addr), .rd_data(a_rd_data));

   adj_time_counter #(.FIXED_MODE(1'b1)) u_fixed (
      .clk(clk), .rst_n(rst_n), .wr_en(f_wr_en), .wr_addr(f_wr_addr),
      .wr_data(f_wr_data), .rd_en(f_rd_en), .rd_addr(f_rd_addr), .rd_data(f_rd_data));

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input bit fx, input logic [4:0] a, input logic [31:0] d);
      if (fx) begin f_wr_en = 1; f_wr_addr = a; f_wr_data = d; end
      else    begin a_wr_en = 1; a_wr_addr = a; a_wr_data = d; end
      @(negedge clk);
      f_wr_en = 0; a_wr_en = 0;
   endtask

   task automatic rd(input bit fx, input logic [4:0] a, output logic [31:0] d);
      if (fx) begin f_rd_en = 1; f_rd_addr = a; end
      else    begin a_rd_en = 1; a_rd_addr = a; end
      #1 d = fx ? f_rd_data : a_rd_data;
      @(negedge clk);
      f_rd_en = 0; a_rd_en = 0;
   endtask

   task automatic load_time(input bit fx, input logic [31:0] r, input logic [63:0] t);
      wr(fx, RES, r);
      wr(fx, LO, t[31:0]);
      wr(fx, HI, t[63:32]);
   endtask

   task automatic read_time(input bit fx, output logic [31:0] r, output logic [63:0] t);
      logic [31:0] lo, hi;
      rd(fx, RES, r);
      rd(fx, LO, lo);
      rd(fx, HI, hi);
      t = {hi, lo};
   endtask

   task automatic run_for(input bit fx, input int n);
      wr(fx, AUX, 32'h0);
      repeat (n - 1) @(negedge clk);
      wr(fx, AUX, STOP);
   endtask

   task automatic t_reset();
      logic [31:0] d, r; logic [63:0] t;
      rd(0, HI, d);   check("R1 high before snapshot", 64'(d), 0);
      rd(0, INC, d);  check("R1 increment", 64'(d), 0);
      rd(0, AUX, d);  check("R1 aux running", 64'(d), 0);
      read_time(0, r, t);
      check("R1 time", t, 0);
      check("R1 residue", 64'(r), 0);
   endtask

   task automatic t_rate();
      logic [31:0] r; logic [63:0] t;
      wr(0, AUX, STOP);
      load_time(0, 0, 0);
      wr(0, INC, {8'd1, 24'h80_0000});
      run_for(0, 4);
      read_time(0, r, t);
      check("R2 period 1 nominal step", t, 64'h200_0000);
      load_time(0, 0, 0);
      wr(0, INC, {8'd3, 24'd7});
      run_for(0, 10);
      read_time(0, r, t);
      check("R2 period 3 step 7", t, 64'd21);
   endtask

   task automatic t_period_zero();
      logic [31:0] r; logic [63:0] t;
      load_time(0, 0, 64'h55);
      wr(0, INC, {8'd0, 24'd5});
      run_for(0, 10);
      read_time(0, r, t);
      check("R3 period zero holds", t, 64'h55);
   endtask

   task automatic t_snapshot();
      logic [31:0] d;
      load_time(0, 32'hABCD, 64'd100);
      wr(0, INC, {8'd1, 24'd1});
      wr(0, AUX, 32'h0);
      repeat (2) @(negedge clk);
      rd(0, RES, d);  check("R4 residue live", 64'(d), 64'hABCD);
      repeat (5) @(negedge clk);
      rd(0, LO, d);   check("R4 low from snapshot", 64'(d), 64'd102);
      rd(0, HI, d);   check("R4 high from snapshot", 64'(d), 0);
      wr(0, AUX, STOP);
   endtask

   task automatic t_staging();
      logic [31:0] r; logic [63:0] t;
      load_time(0, 32'h11, 64'h1_0000_0002);
      wr(0, RES, 32'h22);
      wr(0, LO, 32'h33);
      read_time(0, r, t);
      check("R5 staged low not applied", t, 64'h1_0000_0002);
      check("R5 staged residue not applied", 64'(r), 64'h11);
      wr(0, HI, 32'h44);
      read_time(0, r, t);
      check("R5 commit time", t, 64'h44_0000_0033);
      check("R5 commit residue", 64'(r), 64'h22);
   endtask

   task automatic t_commit_wins();
      logic [31:0] r; logic [63:0] t;
      wr(0, INC, {8'd1, 24'd1});
      wr(0, AUX, 32'h0);
      wr(0, RES, 32'h5);
      wr(0, LO, 32'h1000);
      wr(0, HI, 32'h0);
      wr(0, AUX, STOP);
      read_time(0, r, t);
      check("R6 commit beats addition", t, 64'h1001);
      check("R6 residue", 64'(r), 64'h5);
   endtask

   task automatic t_stop();
      logic [31:0] r, d; logic [63:0] t;
      load_time(0, 0, 64'h777);
      wr(0, INC, {8'd1, 24'd1});
      repeat (10) @(negedge clk);
      read_time(0, r, t);
      check("R7 stopped holds", t, 64'h777);
      rd(0, AUX, d);  check("R7 aux readback", 64'(d), 64'h8000_0000);
      run_for(0, 5);
      read_time(0, r, t);
      check("R7 resume", t, 64'h77C);
   endtask

   task automatic t_wrap();
      logic [31:0] r; logic [63:0] t;
      load_time(0, 0, 64'hFFFF_FFFF_FFFF_FFFE);
      wr(0, INC, {8'd1, 24'd1});
      run_for(0, 3);
      read_time(0, r, t);
      check("R8 wrap through zero", t, 64'd1);
      load_time(0, 0, 64'hFF80_0000_8000_0000);
      wr(0, INC, {8'd1, 24'h80_0000});
      run_for(0, 2);
      read_time(0, r, t);
      check("R8 near-rollover preload", t, 64'hFF80_0000_8100_0000);
   endtask

   task automatic t_readback();
      logic [31:0] d;
      wr(0, INC, 32'h0312_3456);
      rd(0, INC, d);
      check("R10 increment readback", 64'(d), 64'h0312_3456);
   endtask

   task automatic t_fixed();
      logic [31:0] r; logic [63:0] t;
      wr(1, INC, {8'd0, 24'd5});
      wr(1, AUX, STOP);
      load_time(1, 0, 0);
      run_for(1, 6);
      read_time(1, r, t);
      check("R9 fixed step of 8", t, 64'd48);
      check("R9 residue untouched", 64'(r), 0);
   endtask

   initial begin
      #(8 * 100000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rate();
      t_period_zero();
      t_snapshot();
      t_staging();
      t_commit_wins();
      t_stop();
      t_wrap();
      t_readback();
      t_fixed();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule